// File: doc/BRIEF.md
# Windowed Instruction Issue Stage

This block is the issue front end of a core model that fills a fixed-size instruction window. Every cycle it walks up to `IPC` issue slots in order. A slot first spends the compute (non-memory) instructions that come ahead of the current trace entry. Once that count reaches zero, the slot turns to the entry's memory read. The read is handled in one of three ways:

- It merges into a block that is already in flight in the window.
- It completes as a first-level cache hit.
- It becomes a true miss, which takes an entry in an internal miss-tracking table and one memory-controller request.

At most one miss issues per cycle. A failed allocation raises a retry flag, and the request is not consumed.

The window is a circular buffer. Its entries carry a block address and a ready bit. A read response marks every entry of its block ready and frees the block's miss-table entries. Ready entries leave from the head in order, up to `IPC` per cycle. The trace source, the first-level cache lookup and the memory controller are outside the block. The trace entry is held on `req_*_i` until `req_pop_o` pulses. `WIN_DEPTH` must be a power of two.

Top module: `issue_stage`

## Requirements
- R1: At most `IPC` entries enter the window in a cycle (`issue_cnt_o` <= `IPC`), and at most `IPC` leave.
- R2: The window counts as full when its occupancy at the start of a cycle plus the entries already added that cycle reaches `WIN_DEPTH`. If that holds at the first slot, `stall_o` pulses, `stall_cnt_o` increments, and nothing issues. Occupancy never exceeds `WIN_DEPTH`.
- R3: While the entry's compute count is nonzero, each slot decrements it and adds one ready non-memory entry. The count is spent before the read is looked at.
- R4: A miss asserts `mc_valid_o` with `mc_addr_o` equal to the read address and pops the request. No further slot issues in that cycle.
- R5: A read whose block is already in the window is a false miss. It adds an entry whose ready bit copies the existing entries, pops the request, and makes no memory request.
- R6: A read that is not a duplicate but has `l1_hit_i` high adds a ready entry and pops the request. It uses no miss-table entry and makes no memory request.
- R7: If the miss table is full, a would-be miss sets `mshr_retry_o`. The request is not popped and `mc_valid_o` stays low.
- R8: If `mc_ready_i` is low for a would-be miss, `mc_retry_o` is set. The request is not popped and the miss table is unchanged.
- R9: A response (`resp_valid_i`, `resp_addr_i`) marks every window entry of that block ready and frees every miss-table entry of that block.
- R10: Each cycle, entries retire from the head in order. Retirement stops at the first entry that is not ready, and at most `IPC` retire. Occupancy then becomes old + issued − retired.
- R11: A request that failed on retry is presented again and issues once resources allow. The matching retry flag clears when a miss issues.
- R12: After reset the window and miss table are empty, the stall count is zero and both retry flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Trace entry present |
| req_cnt_i | input | CNT_W | Compute instructions ahead of the read |
| req_addr_i | input | ADDR_W | Block address of the read |
| req_pop_o | output | 1 | Trace entry consumed this cycle |
| l1_hit_i | input | 1 | First-level cache holds `req_addr_i` |
| mc_ready_i | input | 1 | Memory controller can accept a request |
| mc_valid_o | output | 1 | Miss request issued |
| mc_addr_o | output | ADDR_W | Block address of the miss |
| resp_valid_i | input | 1 | Read response |
| resp_addr_i | input | ADDR_W | Block address of the response |
| issue_cnt_o | output | $clog2(IPC+1) | Entries added this cycle |
| retire_cnt_o | output | $clog2(IPC+1) | Entries retired this cycle |
| win_cnt_o | output | $clog2(WIN_DEPTH+1) | Window occupancy |
| mshr_cnt_o | output | $clog2(MSHR_DEPTH+1) | Miss-table occupancy |
| stall_o | output | 1 | Full-window stall this cycle |
| stall_cnt_o | output | STALL_W | Stall events since reset |
| mshr_retry_o | output | 1 | Miss-table retry pending |
| mc_retry_o | output | 1 | Memory-controller retry pending |

## Verification
The bench fills the window with one miss and seven merged duplicates of it, so every entry waits on a single response.

- A design that ignored duplicates would send extra memory requests.
- A design that took the full test after retirement would issue into a window that is still full.

Further checks cover the remaining corner cases:

- A duplicate issued after its block's response must come in ready. A design that forced duplicates not-ready would strand it at the head.
- When the miss table or the controller refuses a miss, the same request must wait unpopped and unallocated. A leaky design would lose the read or leave an orphan miss-table entry.
- Retirement must stop at the first unready entry. An out-of-order design would retire a pending miss.

// File: rtl/issue_pkg.sv
package issue_pkg;
  typedef enum logic [2:0] {
    SLOT_IDLE,
    SLOT_CPU,
    SLOT_DUP,
    SLOT_L1,
    SLOT_MISS
  } slot_kind_e;
endpackage

// File: rtl/issue_window.sv
module issue_window #(
  parameter int WIN_DEPTH = 8,
  parameter int ADDR_W    = 12,
  parameter int IPC       = 2,
  localparam int PW = (WIN_DEPTH > 1) ? $clog2(WIN_DEPTH) : 1,
  localparam int CW = $clog2(WIN_DEPTH + 1),
  localparam int NW = $clog2(IPC + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NW-1:0]              add_n_i,
  input  logic [IPC-1:0][ADDR_W-1:0] add_addr_i,
  input  logic [IPC-1:0]             add_mem_i,
  input  logic [IPC-1:0]             add_rdy_i,
  input  logic [ADDR_W-1:0]          lk_addr_i,
  output logic                       lk_hit_o,
  output logic                       lk_rdy_o,
  input  logic                       mark_valid_i,
  input  logic [ADDR_W-1:0]          mark_addr_i,
  output logic [CW-1:0]              cnt_o,
  output logic [NW-1:0]              ret_n_o
);
  logic [ADDR_W-1:0]    addr_q [WIN_DEPTH];
  logic [WIN_DEPTH-1:0] mem_q, rdy_q, live, lk_match, mk_match;
  logic [PW-1:0]        head_q, tail_q;
  logic [CW-1:0]        cnt_q;

  for (genvar g = 0; g < WIN_DEPTH; g++) begin : g_ent
    logic [PW-1:0] off;
    assign off         = PW'(g) - head_q;
    assign live[g]     = (CW'(off) < cnt_q);
    assign lk_match[g] = live[g] && mem_q[g] && (addr_q[g] == lk_addr_i);
    assign mk_match[g] = mark_valid_i && live[g] && mem_q[g] && (addr_q[g] == mark_addr_i);
  end

  assign lk_hit_o = |lk_match;
  assign lk_rdy_o = |(lk_match & rdy_q);

  // in-order retirement from head
  always_comb begin
    logic stop;
    logic [PW-1:0] idx;
    ret_n_o = '0;
    stop    = 1'b0;
    for (int k = 0; k < IPC; k++) begin
      idx = head_q + PW'(k);
      if (!stop && (CW'(k) < cnt_q) && rdy_q[idx]) ret_n_o = ret_n_o + NW'(1);
      else stop = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      mem_q  <= '0;
      rdy_q  <= '0;
      for (int i = 0; i < WIN_DEPTH; i++) addr_q[i] <= '0;
    end else begin
      for (int i = 0; i < WIN_DEPTH; i++) if (mk_match[i]) rdy_q[i] <= 1'b1;
      for (int k = 0; k < IPC; k++) begin
        if (NW'(k) < add_n_i) begin
          addr_q[tail_q + PW'(k)] <= add_addr_i[k];
          mem_q[tail_q + PW'(k)]  <= add_mem_i[k];
          rdy_q[tail_q + PW'(k)]  <= add_rdy_i[k];
        end
      end
      head_q <= head_q + PW'(ret_n_o);
      tail_q <= tail_q + PW'(add_n_i);
      cnt_q  <= cnt_q + CW'(add_n_i) - CW'(ret_n_o);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/issue_mshr.sv
module issue_mshr #(
  parameter int MSHR_DEPTH = 2,
  parameter int ADDR_W     = 12,
  localparam int IW = (MSHR_DEPTH > 1) ? $clog2(MSHR_DEPTH) : 1,
  localparam int MW = $clog2(MSHR_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic              free_i,
  input  logic [ADDR_W-1:0] free_addr_i,
  output logic              full_o,
  output logic [MW-1:0]     cnt_o
);
  logic [ADDR_W-1:0]     addr_q [MSHR_DEPTH];
  logic [MSHR_DEPTH-1:0] vld_q, hit_free;
  logic [IW-1:0]         slot;
  logic                  found;

  for (genvar g = 0; g < MSHR_DEPTH; g++) begin : g_ent
    assign hit_free[g] = free_i && vld_q[g] && (addr_q[g] == free_addr_i);
  end

  always_comb begin
    slot  = '0;
    found = 1'b0;
    for (int i = 0; i < MSHR_DEPTH; i++) begin
      if (!found && !vld_q[i]) begin
        slot  = IW'(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < MSHR_DEPTH; i++) addr_q[i] <= '0;
    end else begin
      for (int i = 0; i < MSHR_DEPTH; i++) if (hit_free[i]) vld_q[i] <= 1'b0;
      if (alloc_i && found) begin
        vld_q[slot]  <= 1'b1;
        addr_q[slot] <= alloc_addr_i;
      end
    end
  end

  assign full_o = &vld_q;
  assign cnt_o  = MW'($countones(vld_q));
endmodule

// File: rtl/issue_slot_ctl.sv
module issue_slot_ctl
  import issue_pkg::*;
#(
  parameter int IPC       = 2,
  parameter int WIN_DEPTH = 8,
  parameter int ADDR_W    = 12,
  parameter int CNT_W     = 4,
  localparam int CW = $clog2(WIN_DEPTH + 1),
  localparam int NW = $clog2(IPC + 1)
) (
  input  logic [CW-1:0]              win_cnt_i,
  input  logic [CNT_W-1:0]           ec_i,
  input  logic                       req_valid_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  input  logic                       dup_hit_i,
  input  logic                       dup_rdy_i,
  input  logic                       resp_valid_i,
  input  logic [ADDR_W-1:0]          resp_addr_i,
  input  logic                       l1_hit_i,
  input  logic                       mshr_full_i,
  input  logic                       mc_ready_i,
  output logic [CNT_W-1:0]           ec_o,
  output logic [NW-1:0]              add_n_o,
  output logic [IPC-1:0][ADDR_W-1:0] add_addr_o,
  output logic [IPC-1:0]             add_mem_o,
  output logic [IPC-1:0]             add_rdy_o,
  output logic                       pop_o,
  output logic                       miss_o,
  output logic                       mshr_fail_o,
  output logic                       mc_fail_o,
  output logic                       stall_o
);
  slot_kind_e kind [IPC];
  logic       halt;
  logic       resp_same;

  assign resp_same = resp_valid_i && (resp_addr_i == req_addr_i);

  always_comb begin
    ec_o        = ec_i;
    add_n_o     = '0;
    pop_o       = 1'b0;
    miss_o      = 1'b0;
    mshr_fail_o = 1'b0;
    mc_fail_o   = 1'b0;
    stall_o     = 1'b0;
    halt        = 1'b0;
    for (int s = 0; s < IPC; s++) begin
      kind[s]       = SLOT_IDLE;
      add_addr_o[s] = '0;
      add_mem_o[s]  = 1'b0;
      add_rdy_o[s]  = 1'b0;
    end
    for (int s = 0; s < IPC; s++) begin
      if (!halt) begin
        if (int'(win_cnt_i) + int'(add_n_o) >= WIN_DEPTH) begin
          if (s == 0) stall_o = 1'b1;
          halt = 1'b1;
        end else if (ec_o != '0) begin
          ec_o    = ec_o - CNT_W'(1);
          kind[s] = SLOT_CPU;
        end else if (!req_valid_i || pop_o) begin
          halt = 1'b1;
        end else if (dup_hit_i) begin
          kind[s] = SLOT_DUP;
          pop_o   = 1'b1;
        end else if (l1_hit_i) begin
          kind[s] = SLOT_L1;
          pop_o   = 1'b1;
        end else if (mshr_full_i) begin
          mshr_fail_o = 1'b1;
          halt        = 1'b1;
        end else if (!mc_ready_i) begin
          mc_fail_o = 1'b1;
          halt      = 1'b1;
        end else begin
          kind[s] = SLOT_MISS;
          pop_o   = 1'b1;
          miss_o  = 1'b1;
          halt    = 1'b1;
        end
        // fill the entry for this slot
        if (kind[s] != SLOT_IDLE) begin
          add_n_o       = add_n_o + NW'(1);
          add_mem_o[s]  = (kind[s] != SLOT_CPU);
          add_addr_o[s] = (kind[s] == SLOT_CPU) ? '0 : req_addr_i;
          unique case (kind[s])
            SLOT_CPU, SLOT_L1: add_rdy_o[s] = 1'b1;
            SLOT_DUP:          add_rdy_o[s] = dup_rdy_i || resp_same;
            default:           add_rdy_o[s] = 1'b0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/issue_stage.sv
module issue_stage #(
  parameter int IPC        = 2,
  parameter int WIN_DEPTH  = 8,
  parameter int MSHR_DEPTH = 2,
  parameter int ADDR_W     = 12,
  parameter int CNT_W      = 4,
  parameter int STALL_W    = 16,
  localparam int CW = $clog2(WIN_DEPTH + 1),
  localparam int NW = $clog2(IPC + 1),
  localparam int MW = $clog2(MSHR_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [CNT_W-1:0]   req_cnt_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  output logic               req_pop_o,
  input  logic               l1_hit_i,
  input  logic               mc_ready_i,
  output logic               mc_valid_o,
  output logic [ADDR_W-1:0]  mc_addr_o,
  input  logic               resp_valid_i,
  input  logic [ADDR_W-1:0]  resp_addr_i,
  output logic [NW-1:0]      issue_cnt_o,
  output logic [NW-1:0]      retire_cnt_o,
  output logic [CW-1:0]      win_cnt_o,
  output logic [MW-1:0]      mshr_cnt_o,
  output logic               stall_o,
  output logic [STALL_W-1:0] stall_cnt_o,
  output logic               mshr_retry_o,
  output logic               mc_retry_o
);
  logic [IPC-1:0][ADDR_W-1:0] add_addr;
  logic [IPC-1:0]             add_mem, add_rdy;
  logic [NW-1:0]              add_n;
  logic [CNT_W-1:0]           ec_in, ec_out, cnt_q;
  logic                       fresh_q;
  logic                       dup_hit, dup_rdy, mshr_full, miss, mshr_fail, mc_fail, pop;
  logic [STALL_W-1:0]         stall_cnt_q;
  logic                       mshr_retry_q, mc_retry_q;

  // a new entry's count is used straight from the input
  assign ec_in = fresh_q ? (req_valid_i ? req_cnt_i : '0) : cnt_q;

  issue_window #(
    .WIN_DEPTH(WIN_DEPTH), .ADDR_W(ADDR_W), .IPC(IPC)
  ) i_window (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .add_n_i     (add_n),
    .add_addr_i  (add_addr),
    .add_mem_i   (add_mem),
    .add_rdy_i   (add_rdy),
    .lk_addr_i   (req_addr_i),
    .lk_hit_o    (dup_hit),
    .lk_rdy_o    (dup_rdy),
    .mark_valid_i(resp_valid_i),
    .mark_addr_i (resp_addr_i),
    .cnt_o       (win_cnt_o),
    .ret_n_o     (retire_cnt_o)
  );

  issue_mshr #(
    .MSHR_DEPTH(MSHR_DEPTH), .ADDR_W(ADDR_W)
  ) i_mshr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (miss),
    .alloc_addr_i(req_addr_i),
    .free_i      (resp_valid_i),
    .free_addr_i (resp_addr_i),
    .full_o      (mshr_full),
    .cnt_o       (mshr_cnt_o)
  );

  issue_slot_ctl #(
    .IPC(IPC), .WIN_DEPTH(WIN_DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) i_slot_ctl (
    .win_cnt_i   (win_cnt_o),
    .ec_i        (ec_in),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .dup_hit_i   (dup_hit),
    .dup_rdy_i   (dup_rdy),
    .resp_valid_i(resp_valid_i),
    .resp_addr_i (resp_addr_i),
    .l1_hit_i    (l1_hit_i),
    .mshr_full_i (mshr_full),
    .mc_ready_i  (mc_ready_i),
    .ec_o        (ec_out),
    .add_n_o     (add_n),
    .add_addr_o  (add_addr),
    .add_mem_o   (add_mem),
    .add_rdy_o   (add_rdy),
    .pop_o       (pop),
    .miss_o      (miss),
    .mshr_fail_o (mshr_fail),
    .mc_fail_o   (mc_fail),
    .stall_o     (stall_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fresh_q      <= 1'b1;
      cnt_q        <= '0;
      stall_cnt_q  <= '0;
      mshr_retry_q <= 1'b0;
      mc_retry_q   <= 1'b0;
    end else begin
      if (pop) begin
        fresh_q <= 1'b1;
        cnt_q   <= '0;
      end else if (!fresh_q || req_valid_i) begin
        fresh_q <= 1'b0;
        cnt_q   <= ec_out;
      end
      if (stall_o) stall_cnt_q <= stall_cnt_q + STALL_W'(1);
      if (miss) begin
        mshr_retry_q <= 1'b0;
        mc_retry_q   <= 1'b0;
      end else begin
        if (mshr_fail) mshr_retry_q <= 1'b1;
        if (mc_fail)   mc_retry_q   <= 1'b1;
      end
    end
  end

  assign req_pop_o    = pop;
  assign mc_valid_o   = miss;
  assign mc_addr_o    = miss ? req_addr_i : '0;
  assign issue_cnt_o  = add_n;
  assign stall_cnt_o  = stall_cnt_q;
  assign mshr_retry_o = mshr_retry_q;
  assign mc_retry_o   = mc_retry_q;
endmodule

// File: rtl/issue_stage_chk.sv
module issue_stage_chk #(
  parameter int IPC        = 2,
  parameter int WIN_DEPTH  = 8,
  parameter int MSHR_DEPTH = 2,
  localparam int CW = $clog2(WIN_DEPTH + 1),
  localparam int NW = $clog2(IPC + 1),
  localparam int MW = $clog2(MSHR_DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_pop_o,
  input logic          mc_valid_o,
  input logic [NW-1:0] issue_cnt_o,
  input logic [NW-1:0] retire_cnt_o,
  input logic [CW-1:0] win_cnt_o,
  input logic [MW-1:0] mshr_cnt_o,
  input logic          stall_o,
  input logic          mshr_retry_o
);
  assert_issue_cap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(issue_cnt_o) <= IPC) && (int'(retire_cnt_o) <= IPC));

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(win_cnt_o) <= WIN_DEPTH);

  assert_stall_blocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (issue_cnt_o == '0));

  assert_miss_pops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_valid_o |-> req_pop_o);

  assert_mshr_room_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_valid_o |-> (int'(mshr_cnt_o) < MSHR_DEPTH));

  assert_retry_no_pop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mshr_retry_o) |-> $past(req_valid_i && !req_pop_o));

  assert_occupancy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (int'(win_cnt_o) ==
              int'($past(win_cnt_o)) + int'($past(issue_cnt_o)) - int'($past(retire_cnt_o))));

  assert_retire_live_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(retire_cnt_o) <= int'(win_cnt_o));
endmodule

bind issue_stage issue_stage_chk #(
  .IPC(IPC), .WIN_DEPTH(WIN_DEPTH), .MSHR_DEPTH(MSHR_DEPTH)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_pop_o   (req_pop_o),
  .mc_valid_o  (mc_valid_o),
  .issue_cnt_o (issue_cnt_o),
  .retire_cnt_o(retire_cnt_o),
  .win_cnt_o   (win_cnt_o),
  .mshr_cnt_o  (mshr_cnt_o),
  .stall_o     (stall_o),
  .mshr_retry_o(mshr_retry_o)
);

// File: tb/test_issue_stage.sv
module test_issue_stage;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int CNT_W  = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [CNT_W-1:0] req_cnt_i = '0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic l1_hit_i = 1'b0;
  logic mc_ready_i = 1'b1;
  logic resp_valid_i = 1'b0;
  logic [ADDR_W-1:0] resp_addr_i = '0;
  logic req_pop_o, mc_valid_o, stall_o, mshr_retry_o, mc_retry_o;
  logic [ADDR_W-1:0] mc_addr_o;
  logic [1:0] issue_cnt_o, retire_cnt_o, mshr_cnt_o;
  logic [3:0] win_cnt_o;
  logic [15:0] stall_cnt_o;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  issue_stage i_issue_stage (
    .clk_i, .rst_ni, .req_valid_i, .req_cnt_i, .req_addr_i, .req_pop_o,
    .l1_hit_i, .mc_ready_i, .mc_valid_o, .mc_addr_o, .resp_valid_i, .resp_addr_i,
    .issue_cnt_o, .retire_cnt_o, .win_cnt_o, .mshr_cnt_o, .stall_o, .stall_cnt_o,
    .mshr_retry_o, .mc_retry_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_req(input logic v, input int cnt, input int addr, input logic l1, input logic mcr);
    req_valid_i = v;
    req_cnt_i   = CNT_W'(cnt);
    req_addr_i  = ADDR_W'(addr);
    l1_hit_i    = l1;
    mc_ready_i  = mcr;
  endtask

  task automatic next();
    @(negedge clk_i);
  endtask

  task automatic drain();
    req_valid_i = 1'b0;
    resp_valid_i = 1'b0;
    repeat (4) next();
  endtask

  task automatic t_reset();
    #1;
    chk("R12 win_cnt", win_cnt_o, 0);
    chk("R12 mshr_cnt", mshr_cnt_o, 0);
    chk("R12 stall_cnt", stall_cnt_o, 0);
    chk("R12 retry flags", {mshr_retry_o, mc_retry_o}, 0);
    chk("R12 no request", mc_valid_o, 0);
  endtask

  task automatic t_compute();
    set_req(1, 3, 'h010, 0, 1); #1;
    chk("R3 two compute slots", issue_cnt_o, 2);
    chk("R3 no pop while count left", req_pop_o, 0);
    chk("R3 no miss yet", mc_valid_o, 0);
    next(); #1;
    chk("R1 compute plus miss", issue_cnt_o, 2);
    chk("R4 miss valid", mc_valid_o, 1);
    chk("R4 miss addr", mc_addr_o, 'h010);
    chk("R4 miss pops", req_pop_o, 1);
    chk("R10 two ready retire", retire_cnt_o, 2);
    next(); req_valid_i = 0; #1;
    chk("R10 occupancy", win_cnt_o, 2);
    chk("R10 stop at unready", retire_cnt_o, 1);
    chk("R4 mshr taken", mshr_cnt_o, 1);
    next(); #1;
    chk("R10 pending miss stays", win_cnt_o, 1);
  endtask

  task automatic t_dup();
    set_req(1, 0, 'h010, 0, 1); #1;
    chk("R5 dup issues", issue_cnt_o, 1);
    chk("R5 dup pops", req_pop_o, 1);
    chk("R5 dup no request", mc_valid_o, 0);
    next(); req_valid_i = 0; resp_valid_i = 1; resp_addr_i = 'h010; #1;
    chk("R5 dup entry held", win_cnt_o, 2);
    chk("R5 dup not ready", retire_cnt_o, 0);
    next(); resp_valid_i = 0; set_req(1, 0, 'h010, 0, 1); #1;
    chk("R9 all block entries ready", retire_cnt_o, 2);
    chk("R9 mshr freed", mshr_cnt_o, 0);
    chk("R5 dup of ready block", req_pop_o, 1);
    chk("R5 dup of ready no request", mc_valid_o, 0);
    next(); req_valid_i = 0; #1;
    chk("R5 inherited ready retires", retire_cnt_o, 1);
    next(); #1;
    chk("R5 window empty", win_cnt_o, 0);
  endtask

  task automatic t_l1();
    set_req(1, 0, 'h020, 1, 1); #1;
    chk("R6 l1 issues", issue_cnt_o, 1);
    chk("R6 l1 pops", req_pop_o, 1);
    chk("R6 l1 no request", mc_valid_o, 0);
    next(); req_valid_i = 0; l1_hit_i = 0; #1;
    chk("R6 l1 no mshr", mshr_cnt_o, 0);
    chk("R6 l1 entry ready", retire_cnt_o, 1);
    next();
  endtask

  task automatic t_mshr();
    set_req(1, 0, 'h030, 0, 1); #1;
    chk("R4 one miss per cycle", issue_cnt_o, 1);
    next(); set_req(1, 0, 'h031, 0, 1); #1;
    chk("R4 second miss", mc_valid_o, 1);
    next(); set_req(1, 0, 'h032, 0, 1); #1;
    chk("R7 mshr full", mshr_cnt_o, 2);
    chk("R7 no pop", req_pop_o, 0);
    chk("R7 no request", mc_valid_o, 0);
    next(); #1;
    chk("R7 retry flag", mshr_retry_o, 1);
    chk("R7 mc flag clear", mc_retry_o, 0);
    chk("R11 still held", req_pop_o, 0);
    resp_valid_i = 1; resp_addr_i = 'h030;
    next(); resp_valid_i = 0; #1;
    chk("R9 one freed", mshr_cnt_o, 1);
    chk("R11 retried miss pops", req_pop_o, 1);
    chk("R11 retried addr", mc_addr_o, 'h032);
    next(); req_valid_i = 0; #1;
    chk("R11 retry flag cleared", mshr_retry_o, 0);
    resp_valid_i = 1; resp_addr_i = 'h031;
    next(); resp_addr_i = 'h032;
    next(); drain(); #1;
    chk("R9 drained window", win_cnt_o, 0);
    chk("R9 drained mshr", mshr_cnt_o, 0);
  endtask

  task automatic t_mc();
    set_req(1, 0, 'h040, 0, 0); #1;
    chk("R8 no pop", req_pop_o, 0);
    chk("R8 no request", mc_valid_o, 0);
    next(); #1;
    chk("R8 mc retry flag", mc_retry_o, 1);
    chk("R8 mshr unchanged", mshr_cnt_o, 0);
    mc_ready_i = 1; #1;
    chk("R11 mc retry issues", mc_valid_o, 1);
    next(); req_valid_i = 0; #1;
    chk("R11 mc flag cleared", mc_retry_o, 0);
    chk("R8 single mshr", mshr_cnt_o, 1);
    resp_valid_i = 1; resp_addr_i = 'h040;
    next(); drain();
  endtask

  task automatic t_full();
    int pops = 0;
    int reqs = 0;
    set_req(1, 0, 'h050, 0, 1);
    for (int c = 0; c < 8; c++) begin
      #1;
      pops += int'(req_pop_o);
      reqs += int'(mc_valid_o);
      next();
    end
    chk("R5 eight pops", pops, 8);
    chk("R5 one request for block", reqs, 1);
    set_req(1, 2, 'h060, 0, 1); #1;
    chk("R2 window full", win_cnt_o, 8);
    chk("R2 stall pulse", stall_o, 1);
    chk("R2 nothing issues", issue_cnt_o, 0);
    next(); resp_valid_i = 1; resp_addr_i = 'h050; #1;
    chk("R2 stall count", stall_cnt_o, 1);
    next(); resp_valid_i = 0; #1;
    chk("R2 full before retire", stall_o, 1);
    chk("R10 capped retire", retire_cnt_o, 2);
    next(); #1;
    chk("R10 occupancy after retire", win_cnt_o, 6);
    chk("R3 compute after stall", issue_cnt_o, 2);
    chk("R2 three stalls", stall_cnt_o, 3);
    next(); drain();
  endtask

  initial begin
    fork
      begin
        repeat (3) next();
        rst_ni = 1'b1;
        t_reset();
        next();
        t_compute();
        t_dup();
        t_l1();
        t_mshr();
        t_mc();
        t_full();
      end
      begin
        repeat (20000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule